// File: doc/BRIEF.md
# Pairwise Widening Accumulate Unit

This unit takes a source vector and an accumulator vector. It splits the source into lanes whose width is chosen at run time. It adds each pair of neighbouring lanes into one result lane that is twice as wide. The result vector therefore has half as many lanes as the source. When accumulation is requested, each widened pair sum is also added to the matching lane of the accumulator vector. That addition wraps within the lane.

Each request arrives with a valid strobe and a set of controls:

- a 2-bit size code that picks the source lane width;
- a width select that picks a 64-bit or a 128-bit vector;
- an accumulate enable;
- a flag that picks zero or sign extension of the source lanes.

The unit has one registered output stage. Its latency is the same one cycle for every input. The reserved size code produces no result. It raises an undefined-encoding flag alongside the output valid instead.

Top module: `pwa_unit`

## Requirements
- R1: Size code 0 selects 8-bit source lanes, code 1 selects 16-bit lanes and code 2 selects 32-bit lanes. Result lanes are twice the source lane width.
- R2: Size code 3 is reserved. The cycle after such a request, `undefFlag` and `outValid` are both 1, and `resVec` keeps its previous value. A request with a legal size code leaves `undefFlag` at 0.
- R3: When `quadSel` is 1 the full 128-bit vector is processed. When it is 0 only bits 63:0 are processed, and bits 127:64 of the result are 0.
- R4: Result lane e, at bit offset e·2W, is formed from source lanes 2e and 2e+1, at bit offsets 2e·W and (2e+1)·W. The number of result lanes is the vector width divided by 2W.
- R5: When `isUnsigned` is 1 each source lane is zero-extended to 2W bits before the pair add. When it is 0 each lane is sign-extended.
- R6: When `accumEn` is 1, the pair sum plus the accumulator lane is stored, modulo 2^(2W). When `accumEn` is 0, the pair sum alone is stored.
- R7: A carry out of the top of any result lane never reaches the lane above it.
- R8: `outValid` equals `inValid` delayed by exactly one cycle for every input. Reset sets `outValid`, `undefFlag` and `resVec` to 0.
- R9: While `inValid` is 0, `resVec` holds its value and `undefFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| sizeCode | input | 2 | Source lane width code (3 is reserved) |
| quadSel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| accumEn | input | 1 | Add pair sums into accumulator lanes |
| isUnsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| srcVec | input | 128 | Source vector |
| accVec | input | 128 | Accumulator vector |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| resVec | output | 128 | Registered result vector |
| undefFlag | output | 1 | Reserved size code was requested |

## Verification
The bench sweeps every byte value through the lowest lane pair with every combination of controls. It then drives patterned and pseudo-random vectors at the wider sizes, and compares each result with an arithmetic model of the lane sums.

Several corner cases are targeted on purpose:

- All-ones inputs with accumulation. A design that let lane carries ripple would corrupt the neighbouring lane.
- Negative lanes with sign extension. A design that ignored the sign flag would yield large positive sums.
- 64-bit mode. A design that did not clear the upper half would leak stale sums there.
- The reserved code. A design that loaded on it would overwrite the held result.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadRes;   // capture the computed vector into the result register
    logic reserved;  // the request carried a reserved size code
  } pwa_strobe_t;
endpackage

// File: rtl/pwa_lane.sv
module pwa_lane #(
  parameter int EW = 8
) (
  input  logic [EW-1:0]   opLo,
  input  logic [EW-1:0]   opHi,
  input  logic [2*EW-1:0] accLane,
  input  logic            accumEn,
  input  logic            isUnsigned,
  output logic [2*EW-1:0] laneOut
);
  localparam int RW = 2 * EW;

  logic [RW-1:0] extLo, extHi, pairSum;

  assign extLo   = {{EW{~isUnsigned & opLo[EW-1]}}, opLo};
  assign extHi   = {{EW{~isUnsigned & opHi[EW-1]}}, opHi};
  assign pairSum = extLo + extHi;
  assign laneOut = accumEn ? (pairSum + accLane) : pairSum;
endmodule

// File: rtl/pwa_ctrl.sv
module pwa_ctrl
  import pwa_pkg::*;
#(
  parameter int NUM_SIZES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  sizeCode,
  output pwa_strobe_t strobe,
  output logic        outValid,
  output logic        undefFlag
);
  logic isReserved;

  assign isReserved      = int'(sizeCode) >= NUM_SIZES;
  assign strobe.loadRes  = inValid & ~isReserved;
  assign strobe.reserved = inValid & isReserved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      undefFlag <= 1'b0;
    end else begin
      outValid  <= inValid;
      undefFlag <= strobe.reserved;
    end
  end
endmodule

// File: rtl/pwa_datapath.sv
module pwa_datapath
  import pwa_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwa_strobe_t      strobe,
  input  logic [1:0]       sizeCode,
  input  logic             quadSel,
  input  logic             accumEn,
  input  logic             isUnsigned,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] accVec,
  output logic [VEC_W-1:0] resVec
);
  localparam int HALF_W = VEC_W / 2;

  logic [NUM_SIZES-1:0][VEC_W-1:0] sizeRes;
  logic [VEC_W-1:0] selRes, nextRes, resReg;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EW = BASE_W << s;
    localparam int RW = 2 * EW;
    localparam int NL = VEC_W / RW;
    for (genvar e = 0; e < NL; e++) begin : g_lane
      pwa_lane #(.EW(EW)) lane_i (
        .opLo      (srcVec[2*e*EW +: EW]),
        .opHi      (srcVec[(2*e+1)*EW +: EW]),
        .accLane   (accVec[e*RW +: RW]),
        .accumEn   (accumEn),
        .isUnsigned(isUnsigned),
        .laneOut   (sizeRes[s][e*RW +: RW])
      );
    end
  end

  always_comb begin
    selRes = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (int'(sizeCode) == s) selRes = sizeRes[s];
    end
    nextRes = selRes;
    if (!quadSel) nextRes[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resReg <= '0;
    else if (strobe.loadRes) resReg <= nextRes;
  end

  assign resVec = resReg;
endmodule

// File: rtl/pwa_unit.sv
module pwa_unit
  import pwa_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       sizeCode,
  input  logic             quadSel,
  input  logic             accumEn,
  input  logic             isUnsigned,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] accVec,
  output logic             outValid,
  output logic [VEC_W-1:0] resVec,
  output logic             undefFlag
);
  pwa_strobe_t strobe;

  pwa_ctrl #(.NUM_SIZES(NUM_SIZES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sizeCode (sizeCode),
    .strobe   (strobe),
    .outValid (outValid),
    .undefFlag(undefFlag)
  );

  pwa_datapath #(.VEC_W(VEC_W), .BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sizeCode  (sizeCode),
    .quadSel   (quadSel),
    .accumEn   (accumEn),
    .isUnsigned(isUnsigned),
    .srcVec    (srcVec),
    .accVec    (accVec),
    .resVec    (resVec)
  );
endmodule

// File: rtl/pwa_unit_chk.sv
module pwa_unit_chk #(
  parameter int VEC_W     = 128,
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       sizeCode,
  input logic             quadSel,
  input logic             accumEn,
  input logic             isUnsigned,
  input logic [VEC_W-1:0] srcVec,
  input logic [VEC_W-1:0] accVec,
  input logic             outValid,
  input logic [VEC_W-1:0] resVec,
  input logic             undefFlag
);
  localparam int HALF_W = VEC_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid) else $error("valid latency");                    // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid) else $error("spurious valid");                 // R8
  AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode == 2'b11) |=> (undefFlag && $stable(resVec)))
    else $error("reserved code");                                          // R2
  AST_LEGAL_NO_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sizeCode != 2'b11) |=> !undefFlag) else $error("undef");   // R2
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !quadSel && sizeCode != 2'b11) |=> (resVec[VEC_W-1:HALF_W] == '0))
    else $error("upper half");                                             // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resVec) && !undefFlag)) else $error("idle hold"); // R9
endmodule

bind pwa_unit pwa_unit_chk #(.VEC_W(VEC_W), .BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) chk_i (.*);

// File: tb/pwa_unit_tb_top.sv
module pwa_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] sizeCode = 2'd0;
  logic quadSel = 1'b0, accumEn = 1'b0, isUnsigned = 1'b0;
  logic [127:0] srcVec = '0, accVec = '0;
  logic outValid, undefFlag;
  logic [127:0] resVec;

  int checks = 0;
  int failures = 0;
  logic [127:0] expHeld = '0;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #2.5 clk = ~clk;

  pwa_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .quadSel(quadSel), .accumEn(accumEn), .isUnsigned(isUnsigned),
    .srcVec(srcVec), .accVec(accVec), .outValid(outValid),
    .resVec(resVec), .undefFlag(undefFlag)
  );

  function automatic logic [127:0] model(int s, bit q, bit acc, bit uns,
                                         logic [127:0] src, logic [127:0] av);
    int w = 8 << s;
    int n = (q ? 128 : 64) / (2 * w);
    logic [127:0] r = '0;
    logic [63:0] m1 = (64'd1 << w) - 64'd1;
    logic [63:0] m2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 64'd1);
    for (int e = 0; e < n; e++) begin
      logic [63:0] a = 64'(src >> (2 * e * w)) & m1;
      logic [63:0] b = 64'(src >> ((2 * e + 1) * w)) & m1;
      logic [63:0] c = 64'(av >> (e * 2 * w)) & m2;
      logic [63:0] sum;
      if (!uns && a[w-1]) a = a | ~m1;
      if (!uns && b[w-1]) b = b | ~m1;
      sum = a + b;
      if (acc) sum = sum + c;
      sum = sum & m2;
      r = r | (128'(sum) << (e * 2 * w));
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    logic [127:0] v;
    for (int i = 0; i < 2; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      v[i*64 +: 64] = lfsr;
    end
    return v;
  endfunction

  task automatic doOp(int s, bit q, bit acc, bit uns, logic [127:0] src,
                      logic [127:0] av, string req);
    logic [127:0] exp;
    @(negedge clk);
    inValid = 1'b1; sizeCode = 2'(s); quadSel = q; accumEn = acc;
    isUnsigned = uns; srcVec = src; accVec = av;
    @(negedge clk);
    inValid = 1'b0;
    if (s == 3) begin
      check(outValid && undefFlag, "R2 flag", {126'd0, outValid, undefFlag}, 128'd3);
      check(resVec == expHeld, "R2 hold", resVec, expHeld);
    end else begin
      exp = model(s, q, acc, uns, src, av);
      check(outValid && !undefFlag, "R8 valid", {126'd0, outValid, undefFlag}, 128'd2);
      check(resVec == exp, req, resVec, exp);
      expHeld = exp;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !undefFlag && resVec == '0, "R8 reset",
          {resVec[125:0], outValid, undefFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6: every byte value through lane pair 0, all control mixes
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int v = 0; v < 256; v++) begin
        logic [127:0] src = {16{8'(v)}};
        src[15:8] = ~8'(v);
        doOp(0, cfg[0], cfg[1], cfg[2], src, rnd128(), "R1 R4 R5 R6 size0 sweep");
      end
    end

    // Wider sizes with patterns and random data
    for (int s = 1; s < 3; s++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        doOp(s, cfg[0], cfg[1], cfg[2], {4{32'h8000_0001}}, {4{32'hFFFF_FFFF}}, "R5 R6 pattern");
        doOp(s, cfg[0], cfg[1], cfg[2], {8{16'h7FFF}}, rnd128(), "R1 R4 max positive");
        for (int k = 0; k < 60; k++)
          doOp(s, cfg[0], cfg[1], cfg[2], rnd128(), rnd128(), "R1 R4 R6 random");
      end
    end

    // R7: all-ones with accumulate makes every lane wrap
    for (int s = 0; s < 3; s++) begin
      doOp(s, 1'b1, 1'b1, 1'b1, '1, '1, "R7 lane isolation unsigned");
      doOp(s, 1'b1, 1'b1, 1'b0, {16{8'h80}}, {16{8'h80}}, "R7 lane isolation signed");
    end

    // R3: 64-bit mode clears upper half after a full-width result
    doOp(0, 1'b1, 1'b0, 1'b1, '1, '0, "R3 full width");
    doOp(2, 1'b0, 1'b1, 1'b1, '1, '1, "R3 half width");
    check(resVec[127:64] == '0, "R3 upper zero", resVec, '0);

    // R2: reserved code holds previous result
    doOp(1, 1'b1, 1'b0, 1'b0, rnd128(), '0, "R2 setup");
    doOp(3, 1'b1, 1'b1, 1'b0, rnd128(), rnd128(), "R2");
    doOp(3, 1'b0, 1'b0, 1'b1, '1, '1, "R2");

    // R9: idle cycles with changing inputs leave outputs untouched
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      srcVec = rnd128(); accVec = rnd128(); sizeCode = 2'(k);
      @(negedge clk);
      check(!outValid && !undefFlag && resVec == expHeld, "R9 idle hold", resVec, expHeld);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule